// File: doc/BRIEF.md
# Multicore External Interrupt Distributor

This block collects a set of level-sensitive external interrupt lines and fans them out to the interrupt inputs of several processor cores. Each line owns a routing word in which bit c sends the line to core c. Two global masks sit between the lines and the cores. The enable mask gates the external levels. The assert mask lets software force a line active, and it works even while that line is disabled. Each mask has its own clear address and its own set address, so software can change single bits without a read-modify-write.

Each core receives a registered output vector. Line i appears at bit i+2 of that vector. Bits 1:0 stay zero in this block, because inter-processor interrupts are generated elsewhere and are merged into those bits downstream. Line index 0 is reserved: external input k drives line k+1, and line 0 can only be raised by a software assert. Straight after reset, core 0 takes every enabled line, even though all routing words read back as zero. Software reaches the registers over a simple synchronous read/write bus.

Top module: `irq_dist`

## Requirements
- R1: For each core c, output bits [LINES+1:2] equal ((synchronized level AND enable) OR assert) AND that core's effective routing, with line i at bit i+2. Bits 1:0 are always 0.
- R2: A write to offset L, for 0 <= L < LINES, stores the routing word of line L; bit c routes line L to core c. A read of offset L returns the stored word.
- R3: A write to 0x180 clears every enable bit whose write-data bit is 1. A write to 0x184 sets every enable bit whose write-data bit is 1. A read of 0x180 returns the enable mask.
- R4: A write to 0x188 clears assert bits and a write to 0x18C sets them, both where the data bit is 1. A read of 0x188 returns the assert mask. An asserted line is active even when its enable bit is 0.
- R5: Reset state:
  - the enable mask is all ones over LINES bits;
  - the assert mask is 0;
  - every routing word reads 0;
  - every output is 0.
- R6: After reset, core 0 receives every enabled line and the other cores receive nothing. A routing write to line L replaces that implicit routing for line L on every core.
- R7: External input bit k is line k+1. Line 0 can only be driven by the assert mask.
- R8: A read of any other offset returns 0, and a write to it changes nothing. This covers routing offsets >= LINES and the set addresses 0x184 and 0x18C.
- R9: Latency:
  - a change on an external input reaches the outputs 3 clock edges later (two synchronizer flops plus the output register);
  - a register write reaches the outputs 1 edge later;
  - read data is valid after the edge that samples the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| extIrq | input | NUM_LINES | Asynchronous external levels; bit k is line k+1 |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | Write when 1, read when 0 |
| busAddr | input | 10 | Register offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered, 0 after non-read cycles |
| irqOut | output | NUM_CORES*(NUM_LINES+3) | Per-core output vectors, core c in slice c |

## Verification
The assertions check four properties on every cycle:
- the two low bits of every core's vector stay zero;
- a read of an unmapped offset returns zero;
- cores other than core 0 stay silent until the first routing write;
- the outputs hold steady whenever the inputs have been quiet and no register write has landed in the window that can reach them.

Several behaviours can only be shown by the directed scenarios. These are:
- the exact masking formula under chosen levels, enables, asserts and routings;
- the set/clear semantics and their readback;
- the hand-off from core 0's implicit routing to an explicit routing word;
- the line numbering offset caused by the reserved index 0;
- the exact three-edge input latency.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ADDR_W = 10;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR = 10'h180;
  localparam logic [ADDR_W-1:0] OFF_EN_SET = 10'h184;
  localparam logic [ADDR_W-1:0] OFF_AS_CLR = 10'h188;
  localparam logic [ADDR_W-1:0] OFF_AS_SET = 10'h18C;

  // Write strobes from control to datapath
  typedef struct packed {
    logic routeWr;
    logic enClr;
    logic enSet;
    logic asClr;
    logic asSet;
  } strobes_t;

  typedef enum logic [1:0] {RD_NONE, RD_ROUTE, RD_EN, RD_AS} rdSel_t;
endpackage

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
  import irq_dist_pkg::*;
#(
  parameter int LINES = 9,
  parameter int IDX_W = 4
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          stb,
  output rdSel_t            rdSel,
  output logic [IDX_W-1:0]  routeIdx
);
  logic routeHit;
  logic doWr;
  logic doRd;

  assign routeHit = busAddr < ADDR_W'(LINES);
  assign doWr     = busSel && busWe;
  assign doRd     = busSel && !busWe;
  assign routeIdx = busAddr[IDX_W-1:0];

  always_comb begin
    stb         = '0;
    stb.routeWr = doWr && routeHit;
    stb.enClr   = doWr && (busAddr == OFF_EN_CLR);
    stb.enSet   = doWr && (busAddr == OFF_EN_SET);
    stb.asClr   = doWr && (busAddr == OFF_AS_CLR);
    stb.asSet   = doWr && (busAddr == OFF_AS_SET);
  end

  always_comb begin
    rdSel = RD_NONE;
    if (doRd) begin
      if (routeHit)                      rdSel = RD_ROUTE;
      else if (busAddr == OFF_EN_CLR)    rdSel = RD_EN;
      else if (busAddr == OFF_AS_CLR)    rdSel = RD_AS;
    end
  end
endmodule

// File: rtl/irq_dist_dp.sv
module irq_dist_dp
  import irq_dist_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int LINES     = 9,
  parameter int IDX_W     = 4,
  localparam int OUT_W    = LINES + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINES-1:0]           rawLines,
  input  strobes_t                   stb,
  input  rdSel_t                     rdSel,
  input  logic [IDX_W-1:0]           routeIdx,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic [NUM_CORES*OUT_W-1:0] irqOut
);
  logic [LINES-1:0]     syncA, syncB;
  logic [LINES-1:0]     enQ, asQ;
  logic [NUM_CORES-1:0] routeQ [LINES];
  logic [LINES-1:0]     effQ   [NUM_CORES];
  logic [LINES-1:0]     activeLines;
  logic [NUM_CORES-1:0] routeRd;

  // Two-flop synchronizer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= rawLines;
      syncB <= syncA;
    end
  end

  // Global masks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enQ <= '1;
      asQ <= '0;
    end else begin
      if (stb.enClr) enQ <= enQ & ~wdata[LINES-1:0];
      if (stb.enSet) enQ <= enQ | wdata[LINES-1:0];
      if (stb.asClr) asQ <= asQ & ~wdata[LINES-1:0];
      if (stb.asSet) asQ <= asQ | wdata[LINES-1:0];
    end
  end

  // Readable routing words and per-core effective routing, one slice per line
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic hit;
    assign hit = stb.routeWr && (routeIdx == IDX_W'(l));

    always_ff @(posedge clk) begin
      if (!rst_n)   routeQ[l] <= '0;
      else if (hit) routeQ[l] <= wdata[NUM_CORES-1:0];
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      always_ff @(posedge clk) begin
        if (!rst_n)   effQ[c][l] <= (c == 0);
        else if (hit) effQ[c][l] <= wdata[c];
      end
    end
  end

  assign activeLines = (syncB & enQ) | asQ;

  // Registered per-core output vectors
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) irqOut[c*OUT_W +: OUT_W] <= '0;
      else        irqOut[c*OUT_W +: OUT_W] <= {activeLines & effQ[c], 2'b00};
    end
  end

  // Routing-word read select
  always_comb begin
    routeRd = '0;
    for (int l = 0; l < LINES; l++)
      if (routeIdx == IDX_W'(l)) routeRd = routeQ[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else begin
      unique case (rdSel)
        RD_ROUTE: rdata <= 32'(routeRd);
        RD_EN:    rdata <= 32'(enQ);
        RD_AS:    rdata <= 32'(asQ);
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  localparam int LINES    = NUM_LINES + 1,
  localparam int OUT_W    = LINES + 2,
  localparam int IDX_W    = $clog2(LINES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       extIrq,
  input  logic                       busSel,
  input  logic                       busWe,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  output logic [NUM_CORES*OUT_W-1:0] irqOut
);
  strobes_t         stb;
  rdSel_t           rdSel;
  logic [IDX_W-1:0] routeIdx;

  irq_dist_ctrl #(.LINES(LINES), .IDX_W(IDX_W)) u_ctrl (
    .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .stb(stb), .rdSel(rdSel), .routeIdx(routeIdx)
  );

  irq_dist_dp #(.NUM_CORES(NUM_CORES), .LINES(LINES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .rawLines({extIrq, 1'b0}),
    .stb(stb), .rdSel(rdSel), .routeIdx(routeIdx), .wdata(busWdata),
    .rdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
  import irq_dist_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  localparam int LINES    = NUM_LINES + 1,
  localparam int OUT_W    = LINES + 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_LINES-1:0]       extIrq,
  input logic                       busSel,
  input logic                       busWe,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [31:0]                busRdata,
  input logic [NUM_CORES*OUT_W-1:0] irqOut
);
  logic wrAny, unmappedRd, seenRoute;

  assign wrAny      = busSel && busWe;
  assign unmappedRd = busSel && !busWe && !(busAddr < ADDR_W'(LINES))
                      && busAddr != OFF_EN_CLR && busAddr != OFF_AS_CLR;

  always_ff @(posedge clk) begin
    if (!rst_n) seenRoute <= 1'b0;
    else if (wrAny && busAddr < ADDR_W'(LINES)) seenRoute <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_low
    assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      irqOut[c*OUT_W +: 2] == 2'b00);
  end

  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unmappedRd |=> busRdata == 32'd0);

  assert_other_cores_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !seenRoute |-> irqOut[NUM_CORES*OUT_W-1:OUT_W] == '0);

  assert_quiet_output_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wrAny, 2) && $past(extIrq, 3) == $past(extIrq, 4)) |-> $stable(irqOut));
endmodule

bind irq_dist irq_dist_chk #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .extIrq(extIrq), .busSel(busSel), .busWe(busWe),
  .busAddr(busAddr), .busRdata(busRdata), .irqOut(irqOut)
);

// File: tb/irq_dist_tb.sv
module irq_dist_tb;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int LINES = NL + 1;
  localparam int OW = LINES + 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [NL-1:0] extIrq = '0;
  logic busSel = 0, busWe = 0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NC*OW-1:0] irqOut;

  int errors = 0, checks = 0;
  bit done = 0;

  // Reference state built from the requirements
  logic [LINES-1:0] mEn, mAs;
  logic [LINES-1:0] mEff [NC];

  always #2.5 clk = ~clk;

  irq_dist #(.NUM_CORES(NC), .NUM_LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .extIrq(extIrq), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] expVec(input int c);
    logic [LINES-1:0] lvl;
    lvl = {extIrq, 1'b0};
    return {((lvl & mEn) | mAs) & mEff[c], 2'b00};
  endfunction

  task automatic chkOuts(input string req);
    for (int c = 0; c < NC; c++)
      chk(req, 32'(irqOut[c*OW +: OW]), 32'(expVec(c)));
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
    if (a < 10'(LINES))
      for (int c = 0; c < NC; c++) mEff[c][a] = d[c];
    else if (a == 10'h180) mEn = mEn & ~d[LINES-1:0];
    else if (a == 10'h184) mEn = mEn | d[LINES-1:0];
    else if (a == 10'h188) mAs = mAs & ~d[LINES-1:0];
    else if (a == 10'h18C) mAs = mAs | d[LINES-1:0];
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    @(negedge clk);
    d = busRdata;
    busSel = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chkOuts("R5 outputs zero after reset");
    rd(10'h180, d); chk("R5 enable reset all ones", d, 32'h1FF);
    rd(10'h188, d); chk("R5 assert reset zero", d, 32'h0);
    rd(10'h003, d); chk("R5 routing word reset zero", d, 32'h0);
  endtask

  task automatic t_core0_default();
    extIrq = 8'h04;            // line 3
    @(negedge clk); @(negedge clk);
    chk("R9 input not yet visible after 2 edges", 32'(irqOut[0 +: OW]), 32'h0);
    @(negedge clk);
    chk("R9 input visible after 3 edges", 32'(irqOut[0 +: OW]), 32'h20);
    chkOuts("R6 core0 takes enabled line, others idle");
  endtask

  task automatic t_routing();
    logic [31:0] d;
    wr(10'd3, 32'h6);
    @(negedge clk);
    chkOuts("R2 line 3 routed to cores 1 and 2");
    chk("R6 core0 loses line 3 after routing write", 32'(irqOut[0 +: OW]), 32'h0);
    rd(10'd3, d); chk("R2 routing readback", d, 32'h6);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(10'h180, 32'h8);
    @(negedge clk);
    chkOuts("R3 cleared enable masks line 3");
    rd(10'h180, d); chk("R3 enable readback after clear", d, 32'h1F7);
    wr(10'h184, 32'h8);
    @(negedge clk);
    chkOuts("R3 set enable restores line 3");
    rd(10'h180, d); chk("R3 enable readback after set", d, 32'h1FF);
  endtask

  task automatic t_assert();
    logic [31:0] d;
    extIrq = '0;
    wr(10'h180, 32'h8);
    wr(10'h18C, 32'h9);        // lines 0 and 3
    wr(10'd0, 32'h8);          // reserved line 0 to core 3
    settle();
    chkOuts("R4 assert forces disabled line and line 0");
    chk("R7 line 0 only via assert, core3 bit2", 32'(irqOut[3*OW +: OW]), 32'h4);
    rd(10'h188, d); chk("R4 assert readback", d, 32'h9);
    wr(10'h188, 32'h9);
    wr(10'h184, 32'h8);
    @(negedge clk);
    chkOuts("R4 assert cleared");
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(10'h190, 32'hFFFF_FFFF);
    wr(10'd9, 32'hF);          // routing offset beyond implemented lines
    @(negedge clk);
    chkOuts("R8 unmapped writes change nothing");
    rd(10'h190, d); chk("R8 unmapped read zero", d, 32'h0);
    rd(10'd9, d);   chk("R8 routing beyond lines reads zero", d, 32'h0);
    rd(10'h184, d); chk("R8 set address reads zero", d, 32'h0);
    rd(10'h18C, d); chk("R8 assert-set address reads zero", d, 32'h0);
    rd(10'h180, d); chk("R8 enable untouched", d, 32'h1FF);
  endtask

  task automatic t_numbering();
    extIrq = 8'h01;            // line 1, bit 3 on core 0
    settle();
    chk("R7 input bit 0 is line 1", 32'(irqOut[0 +: OW]), 32'h8);
    chkOuts("R7 numbering across cores");
  endtask

  task automatic t_pattern();
    wr(10'd1, 32'h3);
    wr(10'd8, 32'hC);
    wr(10'd5, 32'hF);
    extIrq = 8'b1011_0101;
    wr(10'h180, 32'h20);
    wr(10'h18C, 32'h40);
    settle();
    chkOuts("R1 mixed pattern all cores");
    extIrq = 8'b0100_1010;
    settle();
    chkOuts("R1 second pattern all cores");
  endtask

  initial begin
    mEn = '1; mAs = '0;
    for (int c = 0; c < NC; c++) mEff[c] = (c == 0) ? '1 : '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_core0_default();
    t_routing();
    t_enable();
    t_assert();
    t_unmapped();
    t_numbering();
    t_pattern();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule